// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit decides, cycle by cycle, which stages of a five-stage in-order pipeline may advance, which must hold, and which must be loaded with a bubble. The stages, in order, are fetch (IF), decode (ID), operand fetch (OF), execute (EX) and store result (SR). The datapath supplies whether fetch holds an instruction, the decoded register fields and jump flag of the instruction in decode, the outcome of a conditional jump in execute, and the memory requests of fetch and operand fetch. The unit tracks its own valid bit for every stage behind fetch and the destination register of each instruction past decode.

Data hazards are resolved by register locking. An instruction that leaves decode with a destination locks that register. A younger instruction that touches a locked register waits in decode until the writer has completed store result. Control hazards discard younger instructions. An unconditional jump seen in decode discards the one instruction in fetch. A taken conditional jump in execute discards the three instructions in fetch, decode and operand fetch. Fetch and operand fetch share one memory port, and operand fetch wins a collision.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Synchronous active-high reset clears all stage valid bits and all register locks. After reset, an instruction that reads a register locked before the reset proceeds without a hold.
- R2: With no hazard, each valid instruction moves one stage per cycle. All hold and flush bits are 0. Bit positions of `hold_o`, `flush_o` and `stage_vld_o` are 0=IF, 1=ID, 2=OF, 3=EX, 4=SR.
- R3: An instruction leaving decode with a nonzero destination locks it. A younger decode instruction reading that register as either source gets `hold_o`=5'b00011 and `flush_o`=5'b00100. The hold releases in the cycle in which the writer is in SR.
- R4: A decode instruction whose destination is currently locked is held the same way as in R3.
- R5: Register 0 is never locked, and an instruction whose destination-enable is 0 sets no lock.
- R6: When a decode instruction locks the same register that the SR instruction frees in the same cycle, the lock stays set, and the next reader is held.
- R7: An unconditional jump in decode that is not held gives `flush_o`=5'b00010. The next cycle, decode is empty.
- R8: A taken conditional jump in execute gives `flush_o`=5'b01110 and `hold_o`=0. The next cycle, ID, OF and EX are empty and the jump is in SR.
- R9: A conditional jump in execute that is not taken changes nothing.
- R10: An instruction discarded from OF by R8 releases the lock it holds.
- R11: When OF is valid and requests memory in the same cycle as a valid fetch requests memory, fetch is held (`hold_o`=5'b00001), decode receives a bubble (`flush_o`=5'b00010), and OF proceeds.
- R12: A flush overrides any stall. During R8, `hold_o` is 0 even if decode has a lock hazard or the memory port collides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_vld_i | input | 1 | Fetch stage holds an instruction |
| if_mem_req_i | input | 1 | Fetch requests the memory port |
| of_mem_req_i | input | 1 | Operand fetch requests the memory port |
| id_src_a_i | input | RIDX_W | First source register of the decode instruction |
| id_src_a_en_i | input | 1 | First source is read |
| id_src_b_i | input | RIDX_W | Second source register of the decode instruction |
| id_src_b_en_i | input | 1 | Second source is read |
| id_dst_i | input | RIDX_W | Destination register of the decode instruction |
| id_dst_en_i | input | 1 | Decode instruction writes a register |
| id_jmp_i | input | 1 | Decode instruction is an unconditional jump |
| ex_cjmp_i | input | 1 | Execute instruction is a conditional jump |
| ex_taken_i | input | 1 | Execute conditional jump is taken |
| hold_o | output | 5 | Per-stage hold enable |
| flush_o | output | 5 | Per-stage register loads a bubble at the next edge |
| stage_vld_o | output | 5 | Valid bits of IF (input passthrough) and ID..SR |

## Verification
The main function is exercised with a back-to-back read-after-write pair, a write-after-write pair, a chain in which a reader is also a re-writer of the same register, and register-0 and no-destination writers. Together these show whether the stall lasts exactly until the writer is in SR, whether both sources and the destination are checked, and whether a lock set in the release cycle survives. Control flow is tried with an unconditional jump, a taken and a not-taken conditional jump, and a taken jump that lands on top of a lock hazard and a memory collision. These separate flush depth, the lock release of a discarded writer, and flush-over-stall priority. A lone memory collision shows that only fetch yields the port.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
  localparam int STG_N = 5;
  localparam int ST_IF = 0;
  localparam int ST_ID = 1;
  localparam int ST_OF = 2;
  localparam int ST_EX = 3;
  localparam int ST_SR = 4;
endpackage

// File: rtl/hcu_lock_table.sv
module hcu_lock_table #(
  parameter int NREGS  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [RIDX_W-1:0] set_idx,
  input  logic [NREGS-1:0]  clr_vec,
  output logic [NREGS-1:0]  locks_o
);
  logic [NREGS-1:0] lk_q;
  logic [NREGS-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_idx] = 1'b1;
  end

  // set wins over clear on the same register
  always_ff @(posedge clk) begin
    if (rst) lk_q <= '0;
    else     lk_q <= (lk_q & ~clr_vec) | set_vec;
  end

  assign locks_o = lk_q;
endmodule

// File: rtl/hcu_stage_track.sv
module hcu_stage_track
  import hcu_pkg::*;
#(
  parameter int RIDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   if_vld,
  input  logic                   id_den,
  input  logic [RIDX_W-1:0]      id_dst,
  input  logic [STG_N-1:ST_ID]   hold,
  input  logic [STG_N-1:ST_ID]   flush,
  output logic [STG_N-1:ST_ID]   vld_o,
  output logic                   of_den_o,
  output logic [RIDX_W-1:0]      of_dst_o,
  output logic                   sr_den_o,
  output logic [RIDX_W-1:0]      sr_dst_o
);
  logic [STG_N-1:ST_ID] vld_q, vld_d;
  logic [STG_N-1:ST_OF] den_q, den_d;
  logic [STG_N-1:ST_OF][RIDX_W-1:0] dst_q, dst_d;

  always_comb begin
    for (int s = ST_ID; s < STG_N; s++) begin
      logic pv;
      pv = (s == ST_ID) ? if_vld : vld_q[s-1];
      if (hold[s])       vld_d[s] = vld_q[s];
      else if (flush[s]) vld_d[s] = 1'b0;
      else               vld_d[s] = pv;
    end
    for (int s = ST_OF; s < STG_N; s++) begin
      logic              pd;
      logic [RIDX_W-1:0] px;
      pd = (s == ST_OF) ? (id_den & vld_q[ST_ID]) : den_q[s-1];
      px = (s == ST_OF) ? id_dst : dst_q[s-1];
      if (hold[s]) begin
        den_d[s] = den_q[s];
        dst_d[s] = dst_q[s];
      end else begin
        den_d[s] = flush[s] ? 1'b0 : pd;
        dst_d[s] = px;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      den_q <= '0;
      dst_q <= '0;
    end else begin
      vld_q <= vld_d;
      den_q <= den_d;
      dst_q <= dst_d;
    end
  end

  assign vld_o    = vld_q;
  assign of_den_o = den_q[ST_OF];
  assign of_dst_o = dst_q[ST_OF];
  assign sr_den_o = den_q[ST_SR];
  assign sr_dst_o = dst_q[ST_SR];
endmodule

// File: rtl/hcu_hazard_detect.sv
module hcu_hazard_detect
  import hcu_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic [STG_N-1:ST_ID] vld,
  input  logic                 if_vld,
  input  logic                 if_req,
  input  logic                 of_req,
  input  logic [RIDX_W-1:0]    sa,
  input  logic                 sa_en,
  input  logic [RIDX_W-1:0]    sb,
  input  logic                 sb_en,
  input  logic [RIDX_W-1:0]    dd,
  input  logic                 dd_en,
  input  logic                 jmp,
  input  logic                 ex_cj,
  input  logic                 ex_tk,
  input  logic [NREGS-1:0]     locks,
  input  logic                 of_den,
  input  logic [RIDX_W-1:0]    of_dst,
  input  logic                 sr_den,
  input  logic [RIDX_W-1:0]    sr_dst,
  output logic [STG_N-1:0]     hold,
  output logic [STG_N-1:0]     flush,
  output logic                 set_en,
  output logic [RIDX_W-1:0]    set_idx,
  output logic [NREGS-1:0]     clr_vec
);
  logic             taken, raw, memc, jkill;
  logic [NREGS-1:0] rel_vec, lk_eff;

  always_comb begin
    taken   = vld[ST_EX] & ex_cj & ex_tk;
    rel_vec = '0;
    if (vld[ST_SR] & sr_den) rel_vec[sr_dst] = 1'b1;
    lk_eff  = locks & ~rel_vec;
    raw     = vld[ST_ID] & ((sa_en & lk_eff[sa]) | (sb_en & lk_eff[sb]) |
                            (dd_en & lk_eff[dd]));
    memc    = vld[ST_OF] & of_req & if_vld & if_req;
    jkill   = vld[ST_ID] & jmp & ~raw;

    hold  = '0;
    flush = '0;
    if (taken) begin
      flush[ST_ID] = 1'b1;
      flush[ST_OF] = 1'b1;
      flush[ST_EX] = 1'b1;
    end else begin
      hold[ST_ID]  = raw;
      hold[ST_IF]  = raw | (memc & ~jkill);
      flush[ST_OF] = raw;
      flush[ST_ID] = ~raw & (jkill | memc);
    end

    set_en  = vld[ST_ID] & dd_en & ~taken & ~raw;
    set_idx = dd;
    clr_vec = rel_vec;
    if (taken & vld[ST_OF] & of_den) clr_vec[of_dst] = 1'b1;
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hcu_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              if_vld_i,
  input  logic              if_mem_req_i,
  input  logic              of_mem_req_i,
  input  logic [RIDX_W-1:0] id_src_a_i,
  input  logic              id_src_a_en_i,
  input  logic [RIDX_W-1:0] id_src_b_i,
  input  logic              id_src_b_en_i,
  input  logic [RIDX_W-1:0] id_dst_i,
  input  logic              id_dst_en_i,
  input  logic              id_jmp_i,
  input  logic              ex_cjmp_i,
  input  logic              ex_taken_i,
  output logic [4:0]        hold_o,
  output logic [4:0]        flush_o,
  output logic [4:0]        stage_vld_o
);
  logic [STG_N-1:ST_ID] vld;
  logic [STG_N-1:0]     hold, flush;
  logic [NREGS-1:0]     locks, clr_vec;
  logic                 set_en, of_den, sr_den, den_eff;
  logic [RIDX_W-1:0]    set_idx, of_dst, sr_dst;

  // register 0 never takes a lock
  assign den_eff = id_dst_en_i & (id_dst_i != '0);

  hcu_lock_table #(.NREGS(NREGS), .RIDX_W(RIDX_W)) u_locks (
    .clk(clk), .rst(rst), .set_en(set_en), .set_idx(set_idx),
    .clr_vec(clr_vec), .locks_o(locks)
  );

  hcu_stage_track #(.RIDX_W(RIDX_W)) u_track (
    .clk(clk), .rst(rst), .if_vld(if_vld_i), .id_den(den_eff),
    .id_dst(id_dst_i), .hold(hold[STG_N-1:ST_ID]), .flush(flush[STG_N-1:ST_ID]),
    .vld_o(vld), .of_den_o(of_den), .of_dst_o(of_dst),
    .sr_den_o(sr_den), .sr_dst_o(sr_dst)
  );

  hcu_hazard_detect #(.NREGS(NREGS), .RIDX_W(RIDX_W)) u_haz (
    .vld(vld), .if_vld(if_vld_i), .if_req(if_mem_req_i), .of_req(of_mem_req_i),
    .sa(id_src_a_i), .sa_en(id_src_a_en_i), .sb(id_src_b_i), .sb_en(id_src_b_en_i),
    .dd(id_dst_i), .dd_en(den_eff), .jmp(id_jmp_i), .ex_cj(ex_cjmp_i),
    .ex_tk(ex_taken_i), .locks(locks), .of_den(of_den), .of_dst(of_dst),
    .sr_den(sr_den), .sr_dst(sr_dst), .hold(hold), .flush(flush),
    .set_en(set_en), .set_idx(set_idx), .clr_vec(clr_vec)
  );

  assign hold_o      = hold;
  assign flush_o     = flush;
  assign stage_vld_o = {vld, if_vld_i};
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       if_vld_i,
  input logic       if_mem_req_i,
  input logic       of_mem_req_i,
  input logic       id_jmp_i,
  input logic       ex_cjmp_i,
  input logic       ex_taken_i,
  input logic [4:0] hold_o,
  input logic [4:0] flush_o,
  input logic [4:0] stage_vld_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> stage_vld_o[4:1] == 4'b0000);

  // R12
  flush_hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_o & flush_o) == 5'b00000);

  // R8
  taken_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_vld_o[3] & ex_cjmp_i & ex_taken_i) |=> stage_vld_o[3:1] == 3'b000);

  // R3
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o[1] |=> (stage_vld_o[1] & ~stage_vld_o[2]));

  // R7
  jump_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_vld_o[1] & id_jmp_i & ~hold_o[1] & ~flush_o[3]) |=> ~stage_vld_o[1]);

  // R11
  port_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_vld_o[2] & of_mem_req_i & if_vld_i & if_mem_req_i & ~flush_o[3] &
     ~(stage_vld_o[1] & id_jmp_i & ~hold_o[1])) |-> hold_o[0]);
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .if_vld_i(if_vld_i), .if_mem_req_i(if_mem_req_i),
  .of_mem_req_i(of_mem_req_i), .id_jmp_i(id_jmp_i), .ex_cjmp_i(ex_cjmp_i),
  .ex_taken_i(ex_taken_i), .hold_o(hold_o), .flush_o(flush_o),
  .stage_vld_o(stage_vld_o)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       if_vld, if_req, of_req, sae, sbe, de, jmp, cj, tk;
  logic [3:0] sa, sb, dd;
  logic [4:0] hold, flush, svld;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk(clk), .rst(rst), .if_vld_i(if_vld), .if_mem_req_i(if_req),
    .of_mem_req_i(of_req), .id_src_a_i(sa), .id_src_a_en_i(sae),
    .id_src_b_i(sb), .id_src_b_en_i(sbe), .id_dst_i(dd), .id_dst_en_i(de),
    .id_jmp_i(jmp), .ex_cjmp_i(cj), .ex_taken_i(tk),
    .hold_o(hold), .flush_o(flush), .stage_vld_o(svld)
  );

  task automatic clr_in();
    if_vld = 0; if_req = 0; of_req = 0; sae = 0; sbe = 0; de = 0;
    jmp = 0; cj = 0; tk = 0; sa = 0; sb = 0; dd = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr_in();
  endtask

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick(); rst = 1;
    tick(); tick(); rst = 0;
  endtask

  task automatic t_flow();
    do_reset();
    #1; chk("R1 valids after reset", svld, 5'b00000);
    chk("R2 hold idle", hold, 5'b00000);
    if_vld = 1;
    tick(); #1; chk("R2 in ID", svld, 5'b00010);
    tick(); #1; chk("R2 in OF", svld, 5'b00100);
    tick(); #1; chk("R2 in EX", svld, 5'b01000);
    tick(); #1; chk("R2 in SR", svld, 5'b10000);
    chk("R2 flush idle", flush, 5'b00000);
    tick(); #1; chk("R2 drained", svld, 5'b00000);
  endtask

  task automatic t_reset_locks();
    do_reset();
    if_vld = 1;
    tick(); dd = 3; de = 1;
    tick();
    do_reset();
    if_vld = 1;
    tick(); sa = 3; sae = 1; #1;
    chk("R1 lock cleared by reset", hold, 5'b00000);
  endtask

  task automatic t_raw();
    do_reset();
    if_vld = 1;
    tick(); dd = 5; de = 1; if_vld = 1;
    #1; chk("R3 writer passes", hold, 5'b00000);
    tick(); sa = 5; sae = 1;
    #1; chk("R3 hold on read", hold, 5'b00011);
    chk("R3 bubble into OF", flush, 5'b00100);
    tick(); sa = 5; sae = 1;
    #1; chk("R3 still held", hold, 5'b00011);
    tick(); sa = 5; sae = 1;
    #1; chk("R3 released when writer in SR", hold, 5'b00000);
    chk("R3 stage map", svld, 5'b10010);
    tick(); #1; chk("R3 reader moved on", svld, 5'b00100);
  endtask

  task automatic t_waw();
    do_reset();
    if_vld = 1;
    tick(); dd = 6; de = 1; if_vld = 1;
    tick(); sb = 9; sbe = 1; dd = 6; de = 1;
    #1; chk("R4 hold on locked dest", hold, 5'b00011);
  endtask

  task automatic t_reg0();
    do_reset();
    if_vld = 1;
    tick(); dd = 0; de = 1; if_vld = 1;
    tick(); dd = 7; de = 0; if_vld = 1;
    tick(); sa = 0; sae = 1; sb = 7; sbe = 1;
    #1; chk("R5 no lock on r0 or disabled dest", hold, 5'b00000);
  endtask

  task automatic t_setwins();
    do_reset();
    if_vld = 1;
    tick(); dd = 5; de = 1; if_vld = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); sa = 5; sae = 1; dd = 5; de = 1; if_vld = 1;
    end
    #1; chk("R6 rewriter advances", hold, 5'b00000);
    tick(); sa = 5; sae = 1;
    #1; chk("R6 lock kept after same-cycle set", hold, 5'b00011);
    tick(); sa = 5; sae = 1;
    tick(); sa = 5; sae = 1;
    #1; chk("R6 released by rewriter in SR", hold, 5'b00000);
  endtask

  task automatic t_ujmp();
    do_reset();
    if_vld = 1;
    tick(); jmp = 1; if_vld = 1;
    #1; chk("R7 flush fetch slot", flush, 5'b00010);
    chk("R7 no hold", hold, 5'b00000);
    tick(); #1; chk("R7 decode empty", svld, 5'b00100);
  endtask

  task automatic t_cjmp(bit taken);
    do_reset();
    if_vld = 1;
    tick(); if_vld = 1;
    tick(); if_vld = 1; dd = taken ? 4'd4 : 4'd0; de = taken;
    tick(); if_vld = 1; cj = 1; tk = taken;
    if (taken) begin
      sa = 4; sae = 1; if_req = 1; of_req = 1;
    end
    #1; chk(taken ? "R8 full pipe" : "R9 full pipe", svld, 5'b01111);
    if (taken) begin
      chk("R8 flush three", flush, 5'b01110);
      chk("R12 flush beats stall", hold, 5'b00000);
      tick(); if_vld = 1;
      #1; chk("R8 only jump left", svld, 5'b10001);
      tick(); sa = 4; sae = 1;
      #1; chk("R10 discarded lock released", hold, 5'b00000);
    end else begin
      chk("R9 no flush", flush, 5'b00000);
      chk("R9 no hold", hold, 5'b00000);
      tick(); #1; chk("R9 pipe advances", svld, 5'b11110);
    end
  endtask

  task automatic t_mem();
    do_reset();
    if_vld = 1;
    tick(); if_vld = 1;
    tick(); if_vld = 1; if_req = 1; of_req = 1;
    #1; chk("R11 fetch held", hold, 5'b00001);
    chk("R11 bubble into ID", flush, 5'b00010);
    tick(); if_vld = 1;
    #1; chk("R11 OF proceeded", svld, 5'b01101);
    chk("R11 no hold after", hold, 5'b00000);
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr_in();
    t_flow();
    t_reset_locks();
    t_raw();
    t_waw();
    t_reg0();
    t_setwins();
    t_ujmp();
    t_cjmp(1'b1);
    t_cjmp(1'b0);
    t_mem();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule